// File: doc/BRIEF.md
# Multiload Image Loader

This block services a program-load request from the CPU. A read of the load hotspot address, made while the upper cartridge slot maps to ROM, starts a load. The requested load number comes with it. The block walks a store of fixed-size load images and picks the first one whose header carries that number. It copies the image's 256-byte pages into the 8 KB cartridge array at the places the header's per-page descriptors name. Along the way it checks the header sum and every page sum against the constant 0x55. At the end it returns three header bytes to CPU zero-page RAM.

The image store is read asynchronously: the byte for the address the block presents is valid in the same cycle. The block moves one byte per clock. `busy_o` is high from the cycle after the trigger until the last zero-page write. The outcome flags are then held until the next load starts.

Top module: `multiload_loader`

## Requirements
- R1: A load starts only when `cpu_rd_i` is high, `cpu_addr_i` equals 13'h1850 and `upper_rom_i` is high, all in the same cycle with the block idle. `busy_o` is high in the following cycle. Any other access leaves the block idle.
- R2: Each image is 8448 bytes at image-store address index*8448: 8192 page-data bytes, then a 256-byte header. Header byte 5 holds the image's load number. Images are searched from index 0 upward and the first match is used. When no image matches, `missing_o` and `done_o` are set and no cartridge or zero-page write occurs.
- R3: `bad_hdr_o` is set when the 8-bit sum of header bytes 0..7 is not 0x55. The load still completes in full.
- R4: Header byte 3 is the page count. Page j is read from image offset j*256. Its descriptor is header byte 16+j, with bank in bits 1:0 and page-in-bank in bits 4:2. Byte k of the page is written to cartridge address bank*2048 + page*256 + k.
- R5: A page whose descriptor bank is 3 is not written to the cartridge array.
- R6: Page j passes when its 256 data bytes, header byte 16+j and header byte 64+j sum to 0x55 modulo 256. On the first page that fails, `bad_page_o` is set and `bad_page_idx_o` captures j. Later failing pages change neither output.
- R7: After all pages, header bytes 0, 1 and 2 are written to zero-page addresses 0xFE, 0xFF and 0x80, in that order, over three consecutive cycles.
- R8: `done_o`, `missing_o`, `bad_hdr_o`, `bad_page_o` and `bad_page_idx_o` stay unchanged until the next accepted start, which clears them. A trigger that arrives while `busy_o` is high is ignored.
- R9: After reset the block is idle, all status outputs are low, and no write strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_rd_i | input | 1 | CPU read strobe into the cartridge space |
| cpu_addr_i | input | 13 | CPU address |
| upper_rom_i | input | 1 | Upper slot currently maps to ROM |
| load_num_i | input | 8 | Requested load number (CPU RAM byte 0x80) |
| img_addr_o | output | IMG_AW | Image-store byte address |
| img_data_i | input | 8 | Image-store byte, valid in the same cycle |
| cart_we_o | output | 1 | Cartridge array write strobe |
| cart_addr_o | output | 13 | Cartridge array write address |
| cart_data_o | output | 8 | Cartridge array write data |
| zp_we_o | output | 1 | Zero-page write strobe |
| zp_addr_o | output | 8 | Zero-page write address |
| zp_data_o | output | 8 | Zero-page write data |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Last load finished |
| missing_o | output | 1 | Requested load not found |
| bad_hdr_o | output | 1 | Header sum mismatch |
| bad_page_o | output | 1 | At least one page sum mismatch |
| bad_page_idx_o | output | 8 | Index of the first failing page |

## Verification
Three stored images are used. The first load number appears in image 1 and again in image 2, so only a first-match search produces image 1's bytes. That image has a broken header, a bank-3 page with a correct sum, and two later pages with bad sums. This separates header-flag, ROM-skip and first-failure capture from one another. A clean image with three pages spread over banks 0, 1 and 2 at distinct page slots checks the placement arithmetic and the clearing of flags left by the earlier load. An absent load number checks the no-write missing path. Directed cases cover near-miss triggers, a trigger during a load, and flags held while the block is idle.

// File: rtl/ml_pkg.sv
package ml_pkg;
  localparam int unsigned IMG_BYTES  = 8448;
  localparam int unsigned DATA_BYTES = 8192;
  localparam int unsigned NUM_OFF    = 5;
  localparam int unsigned DESC_OFF   = 16;
  localparam int unsigned PSUM_OFF   = 64;
  localparam int unsigned HDR_CHK_N  = 8;
  localparam logic [7:0]  CHK_TARGET = 8'h55;
  localparam logic [12:0] HOT_ADDR   = 13'h1850;
  localparam logic [1:0]  ROM_BANK   = 2'd3;
  localparam logic [7:0]  ZP_A0      = 8'hFE;
  localparam logic [7:0]  ZP_A1      = 8'hFF;
  localparam logic [7:0]  ZP_A2      = 8'h80;

  typedef enum logic [2:0] {
    S_IDLE, S_SCAN, S_HDR, S_PDESC, S_PSUM, S_PCOPY, S_WB
  } ml_state_e;
endpackage

// File: rtl/ml_sum8.sv
module ml_sum8 (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       ld_i,
  input  logic [7:0] data_i,
  output logic [7:0] nxt_o
);
  logic [7:0] acc_q;

  assign nxt_o = (ld_i ? 8'd0 : acc_q) + data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= nxt_o;
  end
endmodule

// File: rtl/ml_addr_gen.sv
module ml_addr_gen
  import ml_pkg::*;
#(
  parameter int unsigned IMG_AW = 15
) (
  input  ml_state_e         st_i,
  input  logic [IMG_AW-1:0] base_i,
  input  logic [7:0]        cnt_i,
  input  logic [7:0]        pg_i,
  output logic [IMG_AW-1:0] addr_o
);
  localparam int unsigned OFF_W = 17;
  localparam logic [OFF_W-1:0] HDR_BASE = OFF_W'(DATA_BYTES);

  logic [OFF_W-1:0] off;

  always_comb begin
    unique case (st_i)
      S_SCAN:  off = HDR_BASE + OFF_W'(NUM_OFF);
      S_HDR:   off = HDR_BASE + OFF_W'(cnt_i);
      S_PDESC: off = HDR_BASE + OFF_W'(DESC_OFF) + OFF_W'(pg_i);
      S_PSUM:  off = HDR_BASE + OFF_W'(PSUM_OFF) + OFF_W'(pg_i);
      S_PCOPY: off = OFF_W'({pg_i, cnt_i});
      default: off = '0;
    endcase
  end

  assign addr_o = base_i + IMG_AW'(off);
endmodule

// File: rtl/multiload_loader.sv
module multiload_loader
  import ml_pkg::*;
#(
  parameter int unsigned NUM_IMAGES = 3,
  parameter int unsigned IMG_AW     = $clog2(NUM_IMAGES * IMG_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_rd_i,
  input  logic [12:0]       cpu_addr_i,
  input  logic              upper_rom_i,
  input  logic [7:0]        load_num_i,
  output logic [IMG_AW-1:0] img_addr_o,
  input  logic [7:0]        img_data_i,
  output logic              cart_we_o,
  output logic [12:0]       cart_addr_o,
  output logic [7:0]        cart_data_o,
  output logic              zp_we_o,
  output logic [7:0]        zp_addr_o,
  output logic [7:0]        zp_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              missing_o,
  output logic              bad_hdr_o,
  output logic              bad_page_o,
  output logic [7:0]        bad_page_idx_o
);
  localparam int unsigned IDX_W = (NUM_IMAGES > 1) ? $clog2(NUM_IMAGES) : 1;
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_IMAGES - 1);
  localparam logic [IMG_AW-1:0] IMG_STEP = IMG_AW'(IMG_BYTES);

  ml_state_e         st_q;
  logic [IMG_AW-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;
  logic [7:0]        cnt_q, pg_q, npg_q, num_q;
  logic [4:0]        desc_q;
  logic [7:0]        b0_q, b1_q, b2_q;
  logic              done_q, miss_q, bhdr_q, bpg_q;
  logic [7:0]        bidx_q;

  logic       trig, sum_en, sum_ld, sum_ok;
  logic [7:0] sum_nxt;

  assign trig   = cpu_rd_i && (cpu_addr_i == HOT_ADDR) && upper_rom_i;
  assign sum_en = st_q inside {S_HDR, S_PDESC, S_PSUM, S_PCOPY};
  assign sum_ld = (st_q == S_PDESC) || (st_q == S_HDR && cnt_q == 8'd0);
  assign sum_ok = (sum_nxt == CHK_TARGET);

  ml_sum8 u_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (sum_en),
    .ld_i   (sum_ld),
    .data_i (img_data_i),
    .nxt_o  (sum_nxt)
  );

  ml_addr_gen #(.IMG_AW(IMG_AW)) u_addr (
    .st_i   (st_q),
    .base_i (base_q),
    .cnt_i  (cnt_q),
    .pg_i   (pg_q),
    .addr_o (img_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      base_q <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      pg_q   <= '0;
      npg_q  <= '0;
      num_q  <= '0;
      desc_q <= '0;
      b0_q   <= '0;
      b1_q   <= '0;
      b2_q   <= '0;
      done_q <= 1'b0;
      miss_q <= 1'b0;
      bhdr_q <= 1'b0;
      bpg_q  <= 1'b0;
      bidx_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (trig) begin
          st_q   <= S_SCAN;
          num_q  <= load_num_i;
          base_q <= '0;
          idx_q  <= '0;
          done_q <= 1'b0;
          miss_q <= 1'b0;
          bhdr_q <= 1'b0;
          bpg_q  <= 1'b0;
          bidx_q <= '0;
        end
        S_SCAN: begin
          if (img_data_i == num_q) begin
            st_q  <= S_HDR;
            cnt_q <= '0;
          end else if (idx_q == LAST_IDX) begin
            st_q   <= S_IDLE;
            miss_q <= 1'b1;
            done_q <= 1'b1;
          end else begin
            idx_q  <= idx_q + 1'b1;
            base_q <= base_q + IMG_STEP;
          end
        end
        S_HDR: begin
          unique case (cnt_q)
            8'd0:    b0_q  <= img_data_i;
            8'd1:    b1_q  <= img_data_i;
            8'd2:    b2_q  <= img_data_i;
            8'd3:    npg_q <= img_data_i;
            default: ;
          endcase
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == 8'(HDR_CHK_N - 1)) begin
            bhdr_q <= !sum_ok;
            cnt_q  <= '0;
            pg_q   <= '0;
            st_q   <= (npg_q == 8'd0) ? S_WB : S_PDESC;
          end
        end
        S_PDESC: begin
          desc_q <= img_data_i[4:0];
          st_q   <= S_PSUM;
        end
        S_PSUM: begin
          cnt_q <= '0;
          st_q  <= S_PCOPY;
        end
        S_PCOPY: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == 8'hFF) begin
            if (!sum_ok && !bpg_q) begin
              bpg_q  <= 1'b1;
              bidx_q <= pg_q;
            end
            pg_q <= pg_q + 1'b1;
            st_q <= (pg_q + 8'd1 == npg_q) ? S_WB : S_PDESC;
          end
        end
        S_WB: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == 8'd2) begin
            st_q   <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign cart_we_o   = (st_q == S_PCOPY) && (desc_q[1:0] != ROM_BANK);
  assign cart_addr_o = {desc_q[1:0], desc_q[4:2], cnt_q};
  assign cart_data_o = img_data_i;

  assign zp_we_o = (st_q == S_WB);
  always_comb begin
    unique case (cnt_q[1:0])
      2'd0:    begin zp_addr_o = ZP_A0; zp_data_o = b0_q; end
      2'd1:    begin zp_addr_o = ZP_A1; zp_data_o = b1_q; end
      default: begin zp_addr_o = ZP_A2; zp_data_o = b2_q; end
    endcase
  end

  assign busy_o         = (st_q != S_IDLE);
  assign done_o         = done_q;
  assign missing_o      = miss_q;
  assign bad_hdr_o      = bhdr_q;
  assign bad_page_o     = bpg_q;
  assign bad_page_idx_o = bidx_q;
endmodule

// File: rtl/ml_loader_chk.sv
module ml_loader_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cpu_rd_i,
  input logic [12:0] cpu_addr_i,
  input logic        upper_rom_i,
  input logic        cart_we_o,
  input logic [12:0] cart_addr_o,
  input logic        zp_we_o,
  input logic [7:0]  zp_addr_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        missing_o,
  input logic        bad_hdr_o,
  input logic        bad_page_o,
  input logic [7:0]  bad_page_idx_o
);
  logic hit;
  assign hit = cpu_rd_i && (cpu_addr_i == 13'h1850) && upper_rom_i;

  a_r1_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && hit) |=> busy_o);

  a_r1_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !hit) |=> !busy_o);

  a_r2_missing_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    missing_o |-> (!busy_o && !cart_we_o && !zp_we_o));

  a_r5_no_rom_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cart_we_o |-> (cart_addr_o[12:11] != 2'b11));

  a_r7_zp_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zp_we_o |-> (zp_addr_o == 8'hFE || zp_addr_o == 8'hFF || zp_addr_o == 8'h80));

  a_r7_zp_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zp_we_o && zp_addr_o == 8'hFE) |=> (zp_we_o && zp_addr_o == 8'hFF));

  a_r6_first_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_page_o && busy_o) |=> (bad_page_o && $stable(bad_page_idx_o)));

  a_r8_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> (busy_o || $stable({done_o, missing_o, bad_hdr_o, bad_page_o, bad_page_idx_o})));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!cart_we_o && !zp_we_o));
endmodule

bind multiload_loader ml_loader_chk u_ml_loader_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cpu_rd_i       (cpu_rd_i),
  .cpu_addr_i     (cpu_addr_i),
  .upper_rom_i    (upper_rom_i),
  .cart_we_o      (cart_we_o),
  .cart_addr_o    (cart_addr_o),
  .zp_we_o        (zp_we_o),
  .zp_addr_o      (zp_addr_o),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .missing_o      (missing_o),
  .bad_hdr_o      (bad_hdr_o),
  .bad_page_o     (bad_page_o),
  .bad_page_idx_o (bad_page_idx_o)
);

// File: tb/test_multiload_loader.sv
module test_multiload_loader;
  localparam int CLK_PERIOD = 10;
  localparam int NIMG   = 3;
  localparam int IMG_AW = $clog2(NIMG * 8448);

  // {bad_idx[19:12], bad_page[11], bad_hdr[10], img[9:8] (3 = missing), load[7:0]}
  localparam logic [19:0] VEC [3] = '{
    {8'd1, 1'b1, 1'b1, 2'd1, 8'h22},
    {8'd0, 1'b0, 1'b0, 2'd0, 8'h11},
    {8'd0, 1'b0, 1'b0, 2'd3, 8'h33}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_rd = 1'b0;
  logic [12:0] cpu_addr = '0;
  logic upper_rom = 1'b0;
  logic [7:0] load_num = '0;
  logic [IMG_AW-1:0] img_addr;
  logic [7:0] img_data;
  logic cart_we, zp_we;
  logic [12:0] cart_addr;
  logic [7:0] cart_data, zp_addr, zp_data;
  logic busy, done, missing, bad_hdr, bad_page;
  logic [7:0] bad_idx;

  int checks = 0;
  int failures = 0;
  int cur_img = 3;
  int wr_cnt, wr_err, rom_wr, zp_cnt;
  logic [7:0] zp_a_log [4];
  logic [7:0] zp_d_log [4];
  logic [7:0] hdr_m [NIMG][256];

  always #(CLK_PERIOD/2) clk = ~clk;

  multiload_loader #(.NUM_IMAGES(NIMG)) i_multiload_loader (
    .clk_i(clk), .rst_ni(rst_n), .cpu_rd_i(cpu_rd), .cpu_addr_i(cpu_addr),
    .upper_rom_i(upper_rom), .load_num_i(load_num), .img_addr_o(img_addr),
    .img_data_i(img_data), .cart_we_o(cart_we), .cart_addr_o(cart_addr),
    .cart_data_o(cart_data), .zp_we_o(zp_we), .zp_addr_o(zp_addr),
    .zp_data_o(zp_data), .busy_o(busy), .done_o(done), .missing_o(missing),
    .bad_hdr_o(bad_hdr), .bad_page_o(bad_page), .bad_page_idx_o(bad_idx)
  );

  function automatic logic [7:0] pat(int i, int o);
    return 8'(i * 61 + o * 13 + (o >> 8) * 5 + 7);
  endfunction

  function automatic logic [7:0] psum(int i, int j);
    logic [7:0] s = 8'd0;
    for (int k = 0; k < 256; k++) s = s + pat(i, j * 256 + k);
    return s;
  endfunction

  always_comb begin
    int a, i, o;
    a = int'(img_addr);
    i = a / 8448;
    o = a % 8448;
    if (i >= NIMG)     img_data = 8'h00;
    else if (o < 8192) img_data = pat(i, o);
    else               img_data = hdr_m[i][o - 8192];
  end

  // stream monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n && cart_we) begin
      logic hit;
      hit = 1'b0;
      wr_cnt++;
      if (cart_addr[12:11] == 2'd3) rom_wr++;
      if (cur_img < NIMG) begin
        for (int j = 0; j < int'(hdr_m[cur_img][3]); j++) begin
          logic [7:0] d;
          d = hdr_m[cur_img][16 + j];
          if ({d[1:0], d[4:2]} == cart_addr[12:8]) begin
            hit = 1'b1;
            if (cart_data != pat(cur_img, j * 256 + int'(cart_addr[7:0]))) wr_err++;
          end
        end
      end
      if (!hit) wr_err++;
    end
    if (rst_n && zp_we) begin
      if (zp_cnt < 4) begin
        zp_a_log[zp_cnt] = zp_addr;
        zp_d_log[zp_cnt] = zp_data;
      end
      zp_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_img(int i, logic [7:0] num, logic [7:0] npg,
                         logic [7:0] b0, logic [7:0] b1, logic [7:0] b2);
    hdr_m[i][0] = b0; hdr_m[i][1] = b1; hdr_m[i][2] = b2;
    hdr_m[i][3] = npg; hdr_m[i][5] = num;
    hdr_m[i][7] = 8'h55 - (b0 + b1 + b2 + npg + num);
  endtask

  task automatic set_page(int i, int j, logic [7:0] desc, bit good);
    hdr_m[i][16 + j] = desc;
    hdr_m[i][64 + j] = 8'h55 - psum(i, j) - desc + (good ? 8'd0 : 8'd1);
  endtask

  task automatic pulse(logic [12:0] a, logic up, logic [7:0] n);
    @(negedge clk);
    cpu_rd = 1'b1; cpu_addr = a; upper_rom = up; load_num = n;
    @(negedge clk);
    cpu_rd = 1'b0; cpu_addr = '0; upper_rom = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int c = 0; c < 5000; c++) begin
      @(negedge clk);
      if (!busy) begin ok = 1'b1; break; end
    end
  endtask

  function automatic int exp_writes(int i);
    int n = 0;
    for (int j = 0; j < int'(hdr_m[i][3]); j++)
      if (hdr_m[i][16 + j][1:0] != 2'd3) n += 256;
    return n;
  endfunction

  task automatic run_and_check(logic [19:0] v, bit inject_busy_trig);
    bit ok;
    int img;
    img = int'(v[9:8]);
    cur_img = img;
    wr_cnt = 0; wr_err = 0; rom_wr = 0; zp_cnt = 0;
    pulse(13'h1850, 1'b1, v[7:0]);
    check(busy == 1'b1, "R1", "busy after trigger", int'(busy), 1);
    if (inject_busy_trig) begin
      repeat (20) @(negedge clk);
      pulse(13'h1850, 1'b1, 8'h33);  // R8: must be ignored
    end
    wait_done(ok);
    check(ok, "R8", "load finished", int'(ok), 1);
    check(done == 1'b1, "R7", "done flag", int'(done), 1);
    if (img == 3) begin
      check(missing == 1'b1, "R2", "missing flag", int'(missing), 1);
      check(wr_cnt == 0 && zp_cnt == 0, "R2", "writes on miss", wr_cnt + zp_cnt, 0);
    end else begin
      check(missing == 1'b0, inject_busy_trig ? "R8" : "R2", "missing flag", int'(missing), 0);
      check(wr_err == 0, "R4", "page data/placement errors", wr_err, 0);
      check(wr_cnt == exp_writes(img), "R4", "cart write count", wr_cnt, exp_writes(img));
      check(rom_wr == 0, "R5", "ROM bank writes", rom_wr, 0);
      check(bad_hdr == v[10], "R3", "bad header flag", int'(bad_hdr), int'(v[10]));
      check(bad_page == v[11], "R6", "bad page flag", int'(bad_page), int'(v[11]));
      check(bad_idx == v[19:12], "R6", "first bad page index", int'(bad_idx), int'(v[19:12]));
      check(zp_cnt == 3, "R7", "zero-page write count", zp_cnt, 3);
      check(zp_a_log[0] == 8'hFE && zp_a_log[1] == 8'hFF && zp_a_log[2] == 8'h80,
            "R7", "zero-page address order", int'({zp_a_log[0], zp_a_log[1], zp_a_log[2]}), 'hFEFF80);
      check(zp_d_log[0] == hdr_m[img][0] && zp_d_log[1] == hdr_m[img][1] &&
            zp_d_log[2] == hdr_m[img][2], "R7", "zero-page data",
            int'({zp_d_log[0], zp_d_log[1], zp_d_log[2]}),
            int'({hdr_m[img][0], hdr_m[img][1], hdr_m[img][2]}));
    end
  endtask

  initial begin
    for (int i = 0; i < NIMG; i++)
      for (int k = 0; k < 256; k++) hdr_m[i][k] = 8'h00;
    // image 0: clean, banks 0/1/2
    set_img(0, 8'h11, 8'd3, 8'hA0, 8'hA1, 8'hA2);
    set_page(0, 0, 8'h00, 1'b1);
    set_page(0, 1, 8'h15, 1'b1);
    set_page(0, 2, 8'h1E, 1'b1);
    // image 1: bad header, ROM-bank page, pages 1 and 2 bad
    set_img(1, 8'h22, 8'd3, 8'hB0, 8'hB1, 8'hB2);
    hdr_m[1][7] = hdr_m[1][7] + 8'd1;
    set_page(1, 0, 8'h07, 1'b1);
    set_page(1, 1, 8'h09, 1'b0);
    set_page(1, 2, 8'h0E, 1'b0);
    // image 2: same number as image 1, must never be chosen
    set_img(2, 8'h22, 8'd1, 8'hC0, 8'hC1, 8'hC2);
    set_page(2, 0, 8'h04, 1'b1);

    repeat (3) @(negedge clk);
    check(!busy && !done && !missing && !bad_hdr && !bad_page && bad_idx == 0 &&
          !cart_we && !zp_we, "R9", "reset state",
          int'({busy, done, missing, bad_hdr, bad_page, cart_we, zp_we}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    pulse(13'h1851, 1'b1, 8'h11);
    @(negedge clk);
    check(!busy, "R1", "wrong address ignored", int'(busy), 0);
    pulse(13'h1850, 1'b0, 8'h11);
    @(negedge clk);
    check(!busy, "R1", "upper slot not ROM ignored", int'(busy), 0);

    for (int v = 0; v < 3; v++) begin
      run_and_check(VEC[v], 1'b0);
      if (v == 0) begin
        repeat (10) @(negedge clk);
        check(bad_hdr && bad_page && bad_idx == 8'd1 && done, "R8", "flags held idle",
              int'({bad_hdr, bad_page, bad_idx}), 'h301);
      end
    end

    run_and_check(VEC[1], 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule